// File: doc/BRIEF.md
# Center-Weighted Exposure Controller

This block closes the automatic exposure loop of a camera pipeline. Over each field it builds a weighted mean of the incoming luminance samples, where samples that fall inside a central window count twice. At the start of vertical blanking it compares that level with a programmable target. It then adjusts two controls: a coarse electronic-shutter step index and a fine digital gain code. The gain code covers 0 to +24 dB in 255 equal steps of 24/255 dB. It fills in the gaps between the shutter's discrete accumulation times, so that the exposure moves smoothly.

An optional three-field running mean of the field levels suppresses flicker from mains-powered lighting. A mode input freezes the shutter, and the loop then acts on the gain alone. The gain multiplier in the pixel path and the sensor timing generator lie outside this block. They consume the shutter index and the gain code that it produces.

Top module: `exposure_ctrl`

## Requirements
- R1: A sample is inside the center window when `h_win` and `v_win` are both high. Such a sample adds twice its luma to the field sum and 2 to the weight count. Every other sample adds its luma once and 1 to the count. The field level is floor(sum / count), or 0 for a field with no samples.
- R2: A sample is taken only on a cycle where `pix_valid` is high and `vblank` is low. Samples on any other cycle have no effect on the outputs.
- R3: A field ends on the cycle in which `vblank` is first sampled high after being low. On the clock edge that samples it, `update_stb` goes high for exactly one cycle, and any change to `shutter_step` and `gain_code` takes effect there. At no other time do these outputs change.
- R4: The level used for control is the measured level. When it lies within target ± `hyst` (both bounds inclusive), the shutter and the gain stay as they are.
- R5: When the measured level is below target − `hyst`, the gain rises by one code. When it is above target + `hyst`, the gain falls by one code. No other change happens while the gain is strictly between 0 and 255.
- R6: In electronic mode (`fixed_mode` low), a call for more exposure while the gain is 255 moves the shutter one step toward 0, which is the longest accumulation. A call for less exposure while the gain is 0 moves it one step toward 15, the shortest. In both cases the gain is set to 128.
- R7: When the shutter is already at the end that a move would need (0 or 15), the gain stays at its limit.
- R8: While `fixed_mode` is high, the shutter never changes. The gain still follows R5 and saturates at 0 and 255.
- R9: Every field level enters a history of the last three levels. With `flicker_en` high, the measured level is the floor of the mean of the entries present, including the current one. Without it, the measured level is the current field level alone.
- R10: Reset sets `shutter_step` to 15, `gain_code` to 0 and `update_stb` to 0, and empties the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Luma sample strobe |
| pix_luma | input | LUMA_W | Luma sample |
| h_win | input | 1 | Sample lies in the central column range |
| v_win | input | 1 | Sample lies in the central line range |
| vblank | input | 1 | Vertical blanking; its rising edge ends a field |
| fixed_mode | input | 1 | High: shutter fixed, gain-only control |
| flicker_en | input | 1 | High: control on the three-field mean |
| target | input | LUMA_W | Desired level |
| hyst | input | LUMA_W | Half-width of the dead band |
| shutter_step | output | 4 | Shutter index, 0 longest, 15 shortest |
| gain_code | output | 8 | Digital gain, 24/255 dB per code |
| update_stb | output | 1 | One-cycle pulse per field update |

## Verification
Two functions can meet on the same field edge: the gain saturating and the shutter stepping with its gain re-centring. The one-code gain walk alone would produce 255 or 0, while the combined move must produce 128 together with a shutter change. The bench provokes this by holding a dark scene for more than two thousand short fields, then a bright scene in both modes. A reference model built from the requirements predicts each field's result, and the bench compares the outputs against it one cycle after each blanking edge. It also checks the saturation hold in the field that follows.

// File: rtl/expo_pkg.sv
package expo_pkg;

    parameter int SHUT_W = 4;
    parameter int GAIN_W = 8;

    localparam logic [SHUT_W-1:0] SHUT_LONGEST  = '0;
    localparam logic [SHUT_W-1:0] SHUT_SHORTEST = '1;
    localparam logic [GAIN_W-1:0] GAIN_MIN      = '0;
    localparam logic [GAIN_W-1:0] GAIN_MAX      = '1;
    localparam logic [GAIN_W-1:0] GAIN_MID      = GAIN_W'(1) << (GAIN_W - 1);

    // Direction the loop wants the exposure to move
    typedef enum logic [1:0] {
        MOVE_HOLD  = 2'd0,
        MOVE_MORE  = 2'd1,
        MOVE_LESS  = 2'd2
    } move_t;

    typedef struct packed {
        logic [SHUT_W-1:0] shutter;
        logic [GAIN_W-1:0] gain;
    } expo_state_t;

    // Gain moves first; at a gain limit the shutter takes one step and gain re-centres.
    function automatic expo_state_t apply_move(expo_state_t cur, move_t mv, logic fixed);
        expo_state_t nxt;
        nxt = cur;
        case (mv)
            MOVE_MORE: begin
                if (cur.gain != GAIN_MAX) begin
                    nxt.gain = cur.gain + 1'b1;
                end else if (!fixed && cur.shutter != SHUT_LONGEST) begin
                    nxt.shutter = cur.shutter - 1'b1;
                    nxt.gain    = GAIN_MID;
                end
            end
            MOVE_LESS: begin
                if (cur.gain != GAIN_MIN) begin
                    nxt.gain = cur.gain - 1'b1;
                end else if (!fixed && cur.shutter != SHUT_SHORTEST) begin
                    nxt.shutter = cur.shutter + 1'b1;
                    nxt.gain    = GAIN_MID;
                end
            end
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/expo_luma_accum.sv
module expo_luma_accum #(
    parameter int LUMA_W    = 8,
    parameter int PIX_CNT_W = 20,
    localparam int CNT_W    = PIX_CNT_W + 1,
    localparam int SUM_W    = LUMA_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_valid,
    input  logic [LUMA_W-1:0] pix_luma,
    input  logic              in_center,
    input  logic              vblank,
    output logic              field_end,
    output logic [SUM_W-1:0]  field_sum,
    output logic [CNT_W-1:0]  field_cnt
);

    logic             vb_q;
    logic [SUM_W-1:0] sum_q;
    logic [CNT_W-1:0] cnt_q;
    logic             take;
    logic [SUM_W-1:0] add_val;
    logic [CNT_W-1:0] add_wt;

    assign take      = pix_valid && !vblank;
    assign field_end = vblank && !vb_q;

    always_comb begin
        if (in_center) begin
            add_val = SUM_W'(pix_luma) << 1;
            add_wt  = CNT_W'(2);
        end else begin
            add_val = SUM_W'(pix_luma);
            add_wt  = CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vb_q  <= 1'b1;
            sum_q <= '0;
            cnt_q <= '0;
        end else begin
            vb_q <= vblank;
            if (field_end) begin
                sum_q <= '0;
                cnt_q <= '0;
            end else if (take) begin
                sum_q <= sum_q + add_val;
                cnt_q <= cnt_q + add_wt;
            end
        end
    end

    assign field_sum = sum_q;
    assign field_cnt = cnt_q;

endmodule

// File: rtl/expo_flicker_hist.sv
module expo_flicker_hist #(
    parameter int LUMA_W     = 8,
    parameter int HIST_DEPTH = 3,
    localparam int N_W       = $clog2(HIST_DEPTH + 1),
    localparam int ACC_W     = LUMA_W + $clog2(HIST_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              field_end,
    input  logic [LUMA_W-1:0] field_avg,
    input  logic              flicker_en,
    output logic [LUMA_W-1:0] level
);

    logic [LUMA_W-1:0] hist_q   [HIST_DEPTH];
    logic [LUMA_W-1:0] hist_nxt [HIST_DEPTH];
    logic [N_W-1:0]    n_q;
    logic [N_W-1:0]    n_nxt;
    logic [ACC_W-1:0]  hist_sum;

    assign hist_nxt[0] = field_avg;

    generate
        for (genvar i = 1; i < HIST_DEPTH; i++) begin : g_shift
            assign hist_nxt[i] = hist_q[i-1];
        end
    endgenerate

    assign n_nxt = (n_q == N_W'(HIST_DEPTH)) ? n_q : n_q + 1'b1;

    // Entries not yet filled are zero, so summing all of them is exact
    always_comb begin
        hist_sum = '0;
        for (int i = 0; i < HIST_DEPTH; i++) begin
            hist_sum = hist_sum + ACC_W'(hist_nxt[i]);
        end
    end

    always_comb begin
        if (flicker_en) begin
            level = LUMA_W'(hist_sum / ACC_W'(n_nxt));
        end else begin
            level = field_avg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            n_q <= '0;
            for (int i = 0; i < HIST_DEPTH; i++) begin
                hist_q[i] <= '0;
            end
        end else if (field_end) begin
            n_q <= n_nxt;
            for (int i = 0; i < HIST_DEPTH; i++) begin
                hist_q[i] <= hist_nxt[i];
            end
        end
    end

endmodule

// File: rtl/expo_step_ctrl.sv
module expo_step_ctrl
    import expo_pkg::*;
#(
    parameter int LUMA_W = 8,
    localparam int CMP_W = LUMA_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              field_end,
    input  logic [LUMA_W-1:0] level,
    input  logic [LUMA_W-1:0] target,
    input  logic [LUMA_W-1:0] hyst,
    input  logic              fixed_mode,
    output expo_state_t       state,
    output logic              update_stb
);

    expo_state_t state_q;
    expo_state_t state_nxt;
    move_t       move;
    logic        too_dark;
    logic        too_bright;

    assign too_dark   = (CMP_W'(level) + CMP_W'(hyst)) < CMP_W'(target);
    assign too_bright = CMP_W'(level) > (CMP_W'(target) + CMP_W'(hyst));

    always_comb begin
        if (too_dark) begin
            move = MOVE_MORE;
        end else if (too_bright) begin
            move = MOVE_LESS;
        end else begin
            move = MOVE_HOLD;
        end
        state_nxt = apply_move(state_q, move, fixed_mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.shutter <= SHUT_SHORTEST;
            state_q.gain    <= GAIN_MIN;
            update_stb      <= 1'b0;
        end else begin
            update_stb <= field_end;
            if (field_end) begin
                state_q <= state_nxt;
            end
        end
    end

    assign state = state_q;

endmodule

// File: rtl/exposure_ctrl.sv
module exposure_ctrl
    import expo_pkg::*;
#(
    parameter int LUMA_W     = 8,
    parameter int PIX_CNT_W  = 20,
    parameter int HIST_DEPTH = 3,
    localparam int CNT_W     = PIX_CNT_W + 1,
    localparam int SUM_W     = LUMA_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_valid,
    input  logic [LUMA_W-1:0] pix_luma,
    input  logic              h_win,
    input  logic              v_win,
    input  logic              vblank,
    input  logic              fixed_mode,
    input  logic              flicker_en,
    input  logic [LUMA_W-1:0] target,
    input  logic [LUMA_W-1:0] hyst,
    output logic [SHUT_W-1:0] shutter_step,
    output logic [GAIN_W-1:0] gain_code,
    output logic              update_stb
);

    logic              field_end;
    logic [SUM_W-1:0]  field_sum;
    logic [CNT_W-1:0]  field_cnt;
    logic [LUMA_W-1:0] field_avg;
    logic [LUMA_W-1:0] level;
    expo_state_t       state;

    expo_luma_accum #(
        .LUMA_W    (LUMA_W),
        .PIX_CNT_W (PIX_CNT_W)
    ) u_accum (
        .clk       (clk),
        .rst       (rst),
        .pix_valid (pix_valid),
        .pix_luma  (pix_luma),
        .in_center (h_win && v_win),
        .vblank    (vblank),
        .field_end (field_end),
        .field_sum (field_sum),
        .field_cnt (field_cnt)
    );

    // Weighted mean never exceeds the largest sample, so it fits LUMA_W
    always_comb begin
        if (field_cnt == '0) begin
            field_avg = '0;
        end else begin
            field_avg = LUMA_W'(field_sum / SUM_W'(field_cnt));
        end
    end

    expo_flicker_hist #(
        .LUMA_W     (LUMA_W),
        .HIST_DEPTH (HIST_DEPTH)
    ) u_hist (
        .clk        (clk),
        .rst        (rst),
        .field_end  (field_end),
        .field_avg  (field_avg),
        .flicker_en (flicker_en),
        .level      (level)
    );

    expo_step_ctrl #(
        .LUMA_W (LUMA_W)
    ) u_step (
        .clk        (clk),
        .rst        (rst),
        .field_end  (field_end),
        .level      (level),
        .target     (target),
        .hyst       (hyst),
        .fixed_mode (fixed_mode),
        .state      (state),
        .update_stb (update_stb)
    );

    assign shutter_step = state.shutter;
    assign gain_code    = state.gain;

endmodule

// File: rtl/exposure_ctrl_chk.sv
module exposure_ctrl_chk
    import expo_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              vblank,
    input logic              fixed_mode,
    input logic [SHUT_W-1:0] shutter_step,
    input logic [GAIN_W-1:0] gain_code,
    input logic              update_stb
);

    AST_STB_AFTER_VBLANK: assert property (@(posedge clk) disable iff (rst)
        update_stb |-> $past(vblank)); // R3

    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        update_stb |=> !update_stb); // R3

    AST_HOLD_BETWEEN_FIELDS: assert property (@(posedge clk) disable iff (rst)
        !update_stb |-> ($stable(shutter_step) && $stable(gain_code))); // R3

    AST_GAIN_SINGLE_CODE: assert property (@(posedge clk) disable iff (rst)
        (update_stb && $stable(shutter_step)) |->
        (gain_code == $past(gain_code) ||
         gain_code == $past(gain_code) + 1'b1 ||
         gain_code == $past(gain_code) - 1'b1)); // R5

    AST_SHUTTER_RECENTRE: assert property (@(posedge clk) disable iff (rst)
        (update_stb && !$stable(shutter_step)) |-> (gain_code == GAIN_MID)); // R6

    AST_SHUTTER_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (update_stb && !$stable(shutter_step)) |->
        (shutter_step == $past(shutter_step) + 1'b1 ||
         shutter_step == $past(shutter_step) - 1'b1)); // R6

    AST_FIXED_SHUTTER: assert property (@(posedge clk) disable iff (rst)
        $past(fixed_mode) |-> $stable(shutter_step)); // R8

endmodule

bind exposure_ctrl exposure_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .vblank       (vblank),
    .fixed_mode   (fixed_mode),
    .shutter_step (shutter_step),
    .gain_code    (gain_code),
    .update_stb   (update_stb)
);

// File: tb/exposure_ctrl_test.sv
module exposure_ctrl_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       pix_valid;
    logic [7:0] pix_luma;
    logic       h_win;
    logic       v_win;
    logic       vblank;
    logic       fixed_mode;
    logic       flicker_en;
    logic [7:0] target;
    logic [7:0] hyst;
    logic [3:0] shutter_step;
    logic [7:0] gain_code;
    logic       update_stb;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Reference model state
    int m_sh;
    int m_gain;
    int mh[3];
    int mn;

    always #10 clk = ~clk;

    exposure_ctrl uut (
        .clk          (clk),
        .rst          (rst),
        .pix_valid    (pix_valid),
        .pix_luma     (pix_luma),
        .h_win        (h_win),
        .v_win        (v_win),
        .vblank       (vblank),
        .fixed_mode   (fixed_mode),
        .flicker_en   (flicker_en),
        .target       (target),
        .hyst         (hyst),
        .shutter_step (shutter_step),
        .gain_code    (gain_code),
        .update_stb   (update_stb)
    );

    // Columns: n_out, l_out, n_cen, l_cen, target, hyst, fixed, flicker, exp_shutter, exp_gain
    localparam int NV = 11;
    localparam int VEC [NV][10] = '{
        '{4,   0, 4,  90,  60,  0, 0, 0, 15, 0},  // R1 weighted 60 on target
        '{4,   0, 4,  90,  61,  0, 0, 0, 15, 1},  // R1 R5 just dark
        '{8, 200, 0,   0, 100, 10, 0, 0, 15, 0},  // R5 bright
        '{8, 200, 0,   0, 100, 10, 0, 0, 15, 0},  // R7 gain 0 at shortest
        '{8, 110, 0,   0, 100, 10, 0, 0, 15, 0},  // R4 upper band edge
        '{8,  89, 0,   0, 100, 10, 0, 0, 15, 1},  // R4 R5 just below band
        '{8,  20, 0,   0,  70,  5, 0, 1, 15, 1},  // R9 mean 73 in band
        '{8,  20, 0,   0,  70,  5, 0, 1, 15, 2},  // R9 mean 43 dark
        '{8, 100, 0,   0, 100,  0, 0, 0, 15, 2},  // R4 exact
        '{8, 250, 0,   0, 100,  0, 1, 0, 15, 1},  // R8 fixed bright
        '{0,   0, 0,   0,  10,  0, 0, 0, 15, 2}   // R1 empty field level 0
    };

    task automatic check(string req, int act, int exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sh   = 15;
        m_gain = 0;
        mn     = 0;
        for (int i = 0; i < 3; i++) mh[i] = 0;
    endtask

    task automatic model_field(int avg);
        int lvl;
        int s;
        mh[2] = mh[1];
        mh[1] = mh[0];
        mh[0] = avg;
        if (mn < 3) mn++;
        s   = mh[0] + mh[1] + mh[2];
        lvl = flicker_en ? s / mn : avg;
        if (lvl + hyst < target) begin
            if (m_gain != 255) m_gain++;
            else if (!fixed_mode && m_sh != 0) begin m_sh--; m_gain = 128; end
        end else if (lvl > target + hyst) begin
            if (m_gain != 0) m_gain--;
            else if (!fixed_mode && m_sh != 15) begin m_sh++; m_gain = 128; end
        end
    endtask

    task automatic put_pix(int lum, bit cen);
        @(negedge clk);
        pix_valid = 1'b1;
        pix_luma  = 8'(lum);
        h_win     = cen;
        v_win     = cen;
    endtask

    // One field: samples, an ignored invalid sample, blanking with an ignored sample
    task automatic run_field(int n_out, int l_out, int n_cen, int l_cen, string req);
        int wsum;
        int wcnt;
        int avg;
        for (int i = 0; i < n_out; i++) put_pix(l_out, 1'b0);
        for (int i = 0; i < n_cen; i++) put_pix(l_cen, 1'b1);
        @(negedge clk);
        pix_valid = 1'b0;
        pix_luma  = 8'd255;
        h_win     = 1'b1;
        v_win     = 1'b1;
        @(negedge clk);
        if (update_stb !== 1'b0) check("R3", int'(update_stb), 0, "strobe before blanking");
        vblank    = 1'b1;
        pix_valid = 1'b1;   // R2: ignored while blanking
        wsum = n_out * l_out + 2 * n_cen * l_cen;
        wcnt = n_out + 2 * n_cen;
        avg  = (wcnt == 0) ? 0 : wsum / wcnt;
        model_field(avg);
        @(negedge clk);
        check("R3", int'(update_stb), 1, "strobe at update");
        check(req, int'(shutter_step), m_sh, "shutter");
        check(req, int'(gain_code), m_gain, "gain");
        @(negedge clk);
        check("R3", int'(update_stb), 0, "strobe after one cycle");
        vblank    = 1'b0;
        pix_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        rst        = 1'b1;
        pix_valid  = 1'b0;
        pix_luma   = '0;
        h_win      = 1'b0;
        v_win      = 1'b0;
        vblank     = 1'b0;
        fixed_mode = 1'b0;
        flicker_en = 1'b0;
        target     = 8'd128;
        hyst       = 8'd0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10", int'(shutter_step), 15, "reset shutter");
        check("R10", int'(gain_code), 0, "reset gain");
        check("R10", int'(update_stb), 0, "reset strobe");

        // Vector table
        for (int v = 0; v < NV; v++) begin
            target     = 8'(VEC[v][4]);
            hyst       = 8'(VEC[v][5]);
            fixed_mode = VEC[v][6][0];
            flicker_en = VEC[v][7][0];
            run_field(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], "R1 R2 R4 R5 R9");
            check("R5", int'(shutter_step), VEC[v][8], "table shutter");
            check("R5", int'(gain_code), VEC[v][9], "table gain");
        end

        // Long dark run: gain saturates, shutter walks to longest with re-centring
        fixed_mode = 1'b0;
        flicker_en = 1'b0;
        target     = 8'd200;
        hyst       = 8'd0;
        for (int f = 0; f < 2200; f++) run_field(1, 0, 0, 0, "R6");
        check("R7", int'(shutter_step), 0, "longest shutter held");
        check("R7", int'(gain_code), 255, "gain held at max");

        // Fixed mode bright: gain only
        fixed_mode = 1'b1;
        target     = 8'd0;
        for (int f = 0; f < 260; f++) run_field(1, 255, 0, 0, "R8");
        check("R8", int'(shutter_step), 0, "fixed keeps shutter");
        check("R8", int'(gain_code), 0, "fixed gain floor");

        // Electronic bright at gain 0: shutter shortens, gain re-centres
        fixed_mode = 1'b0;
        run_field(1, 255, 0, 0, "R6");
        check("R6", int'(shutter_step), 1, "shutter shortened");
        check("R6", int'(gain_code), 128, "gain re-centred");

        // Reset mid-run empties history
        flicker_en = 1'b1;
        do_reset();
        check("R10", int'(shutter_step), 15, "second reset shutter");
        check("R10", int'(gain_code), 0, "second reset gain");
        target = 8'd50;
        hyst   = 8'd0;
        run_field(4, 50, 0, 0, "R9 R10");
        check("R9", int'(gain_code), 0, "fresh history level equals field");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule